// File: doc/BRIEF.md
# Packet Command Phase Sequencer

This block runs the interrupt-driven phases of a packet-protocol command moved by programmed I/O over a byte-register device interface. A request is loaded with a one-cycle `start` pulse. It carries a transfer direction, a total byte budget, a largest allowed chunk, a packet-length selector and the packet words. The block then waits for the device interrupt. On each interrupt it reads four device registers in turn: status, interrupt reason, byte-count low and byte-count high. It merges bits of the first two into a phase code and acts on that code.

Acting on a phase means one of three things. The block may write the command packet to the data register after a settling delay. It may move one chunk of 16-bit words between the data register and a local word buffer. Or it may close the command with a result code. Chunk bookkeeping tracks the bytes done so far and shrinks the allowed chunk as the budget runs out. When the device offers more than the allowed chunk, the surplus is drained on reads and padded with zero words on writes. Every mismatch between the phase and the request direction has its own outcome.

Top module: `pkt_phase_seq`

States: `S_IDLE`, `S_WAIT`, `S_RD_STAT`, `S_RD_RSN`, `S_RD_BCL`, `S_RD_BCH`, `S_LATCH_LEN`, `S_DISPATCH`, `S_SETTLE`, `S_PKT`, `S_XIN_REQ`, `S_XIN_CAP`, `S_XOUT`, `S_CHUNK_END`, `S_RD_ERR`, `S_CAP_ERR`, `S_FINISH`.

Transitions:
- Start: IDLE to WAIT.
- Interrupt: WAIT to RD_STAT.
- Register poll: RD_STAT to RD_RSN to RD_BCL to RD_BCH to LATCH_LEN to DISPATCH.
- Packet: DISPATCH to SETTLE to PKT to WAIT.
- Read chunk: DISPATCH to XIN_REQ, alternating with XIN_CAP, then CHUNK_END.
- Write chunk: DISPATCH to XOUT, then CHUNK_END.
- Empty chunk: DISPATCH to CHUNK_END.
- Chunk end: CHUNK_END to WAIT, or to RD_ERR or FINISH after the final data-with-DRQ chunk.
- Error fetch: RD_ERR to CAP_ERR to FINISH.
- Close: DISPATCH to FINISH, then FINISH to IDLE.

## Requirements
- R1: After reset, `busy`, `cmd_done`, `res_code`, `res_err` and `done_bytes` are all zero.
- R2: An interrupt while no request is active is ignored. No register read or write occurs and `busy` stays low.
- R3: Each interrupt triggers reads of status (address 7), reason (address 2), count-low (address 4) and count-high (address 5). The phase code is {status bit 3 (DRQ), 0, reason bit 1 (IO), reason bit 0 (CoD)}. The byte count is count-low + 256 × count-high.
- R4: Phase 0x9 (command out): after at least SETTLE_CYCLES cycles, the packet is written to data address 0. It is 6 words when `req_pkt12` is 1, else 8, and word i is `pkt_data[16i+15:16i]`. The block then waits for the next interrupt.
- R5: Phase 0xA (data in) on a request with no write direction reads count/2 words from address 0. The first min(count, chunk)/2 words go to buffer word address done/2 + k. The remaining words are read and discarded.
- R6: Phase 0x8 (data out) on a request with no read direction writes count/2 words to address 0. The first min(count, chunk)/2 words come from buffer word address done/2 + k, and the remaining words are zero.
- R7: After each chunk, done increases by the device byte count. The next allowed chunk becomes min(total − done, chunk), with total − done taken as 0 when negative.
- R8: A data-out phase on a read request (`req_dir`=1), or a data-in phase on a write request (`req_dir`=2), closes the command with `res_code`=2 and moves no data.
- R9: Phase 0xB (done with DRQ) moves one more chunk in the request direction and is then handled as done. With no direction (`req_dir`=0), it reads the error register and closes with `res_code`=1.
- R10: Phases 0x3 (done) and 0x1 (abort) behave as follows. If status bit 0 (ERR) or bit 5 (fault) is set, the block reads address 1 into `res_err` and gives `res_code`=1. Otherwise it gives `res_code`=0.
- R11: Any other phase code closes the command with `res_code`=3.
- R12: `cmd_done` is a one-cycle pulse with `busy` low afterwards. `res_code`, `res_err` and `done_bytes` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Load a request (ignored while busy) |
| req_dir | input | 2 | 0 none, 1 read, 2 write |
| req_total | input | 16 | Total byte budget |
| req_chunk | input | 16 | Largest allowed chunk in bytes |
| req_pkt12 | input | 1 | 1: 6-word packet, 0: 8-word packet |
| pkt_data | input | 128 | Packet words, word i at bits 16i+15:16i |
| irq | input | 1 | Device interrupt |
| reg_addr | output | 3 | Device register address |
| reg_rd | output | 1 | Register read; data returned the next cycle |
| reg_wr | output | 1 | Register write |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data |
| buf_addr | output | 16 | Local buffer word address |
| buf_rd | output | 1 | Buffer read; `buf_rdata` valid in the same cycle |
| buf_rdata | input | 16 | Buffer read data |
| buf_wr | output | 1 | Buffer write |
| buf_wdata | output | 16 | Buffer write data |
| busy | output | 1 | Request active |
| cmd_done | output | 1 | Completion pulse |
| res_code | output | 2 | 0 ok, 1 device error, 2 direction error, 3 unknown phase |
| res_err | output | 8 | Captured error register |
| done_bytes | output | 16 | Bytes done |

## Verification
The sequencer is driven with full command flows for each phase kind.

- A read chunk that fits, and a read chunk where the device offers more than the allowed chunk, separate stored words from drained words.
- Write chunks with and without surplus separate buffer words from zero padding.
- A data-with-DRQ phase carrying a byte count above 255 exercises the high count byte and the extra chunk.
- Direction mismatches, an unknown code, a fault-flagged abort and a no-direction data-with-DRQ phase each check that a distinct result code is reached without data movement.
- An idle interrupt shows that no register access starts.

// File: rtl/pkt_phase_pkg.sv
package pkt_phase_pkg;

    typedef enum logic [2:0] {
        PH_CMD_OUT,
        PH_DATA_OUT,
        PH_DATA_IN,
        PH_END_DRQ,
        PH_END,
        PH_ABORT,
        PH_BAD
    } phase_e;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_DEV   = 2'd1,
        RES_DIR   = 2'd2,
        RES_PHASE = 2'd3
    } res_e;

    localparam logic [1:0] DIR_RD = 2'd1;
    localparam logic [1:0] DIR_WR = 2'd2;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_ERR  = 3'd1;
    localparam logic [2:0] A_RSN  = 3'd2;
    localparam logic [2:0] A_BCL  = 3'd4;
    localparam logic [2:0] A_BCH  = 3'd5;
    localparam logic [2:0] A_STAT = 3'd7;

    localparam int ST_ERR = 0;
    localparam int ST_DRQ = 3;
    localparam int ST_DF  = 5;
    localparam int RS_COD = 0;
    localparam int RS_IO  = 1;

    typedef enum logic [4:0] {
        S_IDLE,
        S_WAIT,
        S_RD_STAT,
        S_RD_RSN,
        S_RD_BCL,
        S_RD_BCH,
        S_LATCH_LEN,
        S_DISPATCH,
        S_SETTLE,
        S_PKT,
        S_XIN_REQ,
        S_XIN_CAP,
        S_XOUT,
        S_CHUNK_END,
        S_RD_ERR,
        S_CAP_ERR,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/pkt_phase_decode.sv
module pkt_phase_decode
    import pkt_phase_pkg::*;
(
    input  logic   drq,
    input  logic   io,
    input  logic   cod,
    output phase_e phase
);
    logic [3:0] code;

    assign code = {drq, 1'b0, io, cod};

    always_comb begin
        unique case (code)
            4'h9:    phase = PH_CMD_OUT;
            4'h8:    phase = PH_DATA_OUT;
            4'hA:    phase = PH_DATA_IN;
            4'hB:    phase = PH_END_DRQ;
            4'h3:    phase = PH_END;
            4'h1:    phase = PH_ABORT;
            default: phase = PH_BAD;
        endcase
    end
endmodule

// File: rtl/pkt_chunk_calc.sv
module pkt_chunk_calc #(
    parameter int BC_W = 16
) (
    input  logic [BC_W-1:0] total,
    input  logic [BC_W-1:0] done,
    input  logic [BC_W-1:0] chunk,
    input  logic [BC_W-1:0] len,
    output logic [BC_W-1:0] use_words,
    output logic [BC_W-1:0] all_words,
    output logic [BC_W-1:0] next_done,
    output logic [BC_W-1:0] next_chunk
);
    logic [BC_W-1:0] eff;
    logic [BC_W-1:0] rem;

    always_comb begin
        eff        = (len < chunk) ? len : chunk;
        use_words  = eff >> 1;
        all_words  = len >> 1;
        next_done  = done + len;
        rem        = (total > next_done) ? (total - next_done) : '0;
        next_chunk = (rem < chunk) ? rem : chunk;
    end
endmodule

// File: rtl/pkt_settle_timer.sv
module pkt_settle_timer #(
    parameter int SETTLE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run && (cnt_q <= CW'(1));
endmodule

// File: rtl/pkt_phase_seq.sv
module pkt_phase_seq
    import pkt_phase_pkg::*;
#(
    parameter int BC_W            = 16,
    parameter int DW              = 16,
    parameter int PKT_WORDS_MAX   = 8,
    parameter int PKT_WORDS_SHORT = 6,
    parameter int SETTLE_CYCLES   = 2000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  req_dir,
    input  logic [BC_W-1:0]             req_total,
    input  logic [BC_W-1:0]             req_chunk,
    input  logic                        req_pkt12,
    input  logic [DW*PKT_WORDS_MAX-1:0] pkt_data,
    input  logic                        irq,
    output logic [2:0]                  reg_addr,
    output logic                        reg_rd,
    output logic                        reg_wr,
    output logic [DW-1:0]               reg_wdata,
    input  logic [DW-1:0]               reg_rdata,
    output logic [BC_W-1:0]             buf_addr,
    output logic                        buf_rd,
    input  logic [DW-1:0]               buf_rdata,
    output logic                        buf_wr,
    output logic [DW-1:0]               buf_wdata,
    output logic                        busy,
    output logic                        cmd_done,
    output logic [1:0]                  res_code,
    output logic [7:0]                  res_err,
    output logic [BC_W-1:0]             done_bytes
);
    localparam int PKT_W     = DW * PKT_WORDS_MAX;
    localparam int PKT_IDX_W = $clog2(PKT_WORDS_MAX);

    seq_state_e state_q, state_d;

    logic [1:0]       dir_q;
    logic [BC_W-1:0]  total_q, chunk_q, done_q, len_q, wcnt_q;
    logic             pkt12_q;
    logic [PKT_W-1:0] pkt_q;
    logic             drq_q, io_q, cod_q, st_err_q, st_df_q;
    logic [7:0]       bcl_q, err_q;
    logic             end_drq_q, force_err_q;
    res_e             res_q;

    phase_e           phase;
    logic [BC_W-1:0]  use_words, all_words, next_done, next_chunk;
    logic [BC_W-1:0]  pkt_words;
    logic             is_rd, is_wr, fault, real_word;
    logic             settle_load, settle_run, settle_done;
    logic [PKT_IDX_W-1:0] pidx;

    pkt_phase_decode u_dec (
        .drq   (drq_q),
        .io    (io_q),
        .cod   (cod_q),
        .phase (phase)
    );

    pkt_chunk_calc #(.BC_W(BC_W)) u_calc (
        .total      (total_q),
        .done       (done_q),
        .chunk      (chunk_q),
        .len        (len_q),
        .use_words  (use_words),
        .all_words  (all_words),
        .next_done  (next_done),
        .next_chunk (next_chunk)
    );

    pkt_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .run     (settle_run),
        .expired (settle_done)
    );

    assign is_rd       = (dir_q == DIR_RD);
    assign is_wr       = (dir_q == DIR_WR);
    assign fault       = st_err_q | st_df_q | force_err_q;
    assign pkt_words   = pkt12_q ? BC_W'(PKT_WORDS_SHORT) : BC_W'(PKT_WORDS_MAX);
    assign real_word   = (wcnt_q < use_words);
    assign pidx        = wcnt_q[PKT_IDX_W-1:0];
    assign settle_load = (state_q == S_DISPATCH);
    assign settle_run  = (state_q == S_SETTLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_WAIT;
            S_WAIT:      if (irq) state_d = S_RD_STAT;
            S_RD_STAT:   state_d = S_RD_RSN;
            S_RD_RSN:    state_d = S_RD_BCL;
            S_RD_BCL:    state_d = S_RD_BCH;
            S_RD_BCH:    state_d = S_LATCH_LEN;
            S_LATCH_LEN: state_d = S_DISPATCH;
            S_DISPATCH: begin
                unique case (phase)
                    PH_CMD_OUT:  state_d = S_SETTLE;
                    PH_DATA_OUT: state_d = is_rd ? S_FINISH
                                         : (all_words == '0 ? S_CHUNK_END : S_XOUT);
                    PH_DATA_IN:  state_d = is_wr ? S_FINISH
                                         : (all_words == '0 ? S_CHUNK_END : S_XIN_REQ);
                    PH_END_DRQ: begin
                        if (all_words == '0 && (is_rd || is_wr)) state_d = S_CHUNK_END;
                        else if (is_rd)                          state_d = S_XIN_REQ;
                        else if (is_wr)                          state_d = S_XOUT;
                        else                                     state_d = S_RD_ERR;
                    end
                    PH_END, PH_ABORT: state_d = fault ? S_RD_ERR : S_FINISH;
                    default:     state_d = S_FINISH;
                endcase
            end
            S_SETTLE:    if (settle_done) state_d = S_PKT;
            S_PKT:       if (wcnt_q == pkt_words - 1'b1) state_d = S_WAIT;
            S_XIN_REQ:   state_d = S_XIN_CAP;
            S_XIN_CAP:   state_d = (wcnt_q == all_words - 1'b1) ? S_CHUNK_END : S_XIN_REQ;
            S_XOUT:      if (wcnt_q == all_words - 1'b1) state_d = S_CHUNK_END;
            S_CHUNK_END: begin
                if (!end_drq_q) state_d = S_WAIT;
                else if (fault) state_d = S_RD_ERR;
                else            state_d = S_FINISH;
            end
            S_RD_ERR:    state_d = S_CAP_ERR;
            S_CAP_ERR:   state_d = S_FINISH;
            S_FINISH:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Request and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q       <= '0;
            total_q     <= '0;
            chunk_q     <= '0;
            done_q      <= '0;
            len_q       <= '0;
            wcnt_q      <= '0;
            pkt12_q     <= 1'b0;
            pkt_q       <= '0;
            drq_q       <= 1'b0;
            io_q        <= 1'b0;
            cod_q       <= 1'b0;
            st_err_q    <= 1'b0;
            st_df_q     <= 1'b0;
            bcl_q       <= '0;
            err_q       <= '0;
            end_drq_q   <= 1'b0;
            force_err_q <= 1'b0;
            res_q       <= RES_OK;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    dir_q       <= req_dir;
                    total_q     <= req_total;
                    chunk_q     <= req_chunk;
                    pkt12_q     <= req_pkt12;
                    pkt_q       <= pkt_data;
                    done_q      <= '0;
                    err_q       <= '0;
                    end_drq_q   <= 1'b0;
                    force_err_q <= 1'b0;
                    res_q       <= RES_OK;
                end
                S_RD_RSN: begin
                    drq_q    <= reg_rdata[ST_DRQ];
                    st_err_q <= reg_rdata[ST_ERR];
                    st_df_q  <= reg_rdata[ST_DF];
                end
                S_RD_BCL: begin
                    io_q  <= reg_rdata[RS_IO];
                    cod_q <= reg_rdata[RS_COD];
                end
                S_RD_BCH:    bcl_q <= reg_rdata[7:0];
                S_LATCH_LEN: len_q <= {{(BC_W-16){1'b0}}, reg_rdata[7:0], bcl_q};
                S_DISPATCH: begin
                    wcnt_q      <= '0;
                    end_drq_q   <= (phase == PH_END_DRQ);
                    force_err_q <= (phase == PH_END_DRQ) && !is_rd && !is_wr;
                    if ((phase == PH_DATA_OUT && is_rd) || (phase == PH_DATA_IN && is_wr))
                        res_q <= RES_DIR;
                    else if (phase == PH_BAD)
                        res_q <= RES_PHASE;
                end
                S_PKT, S_XIN_CAP, S_XOUT: wcnt_q <= wcnt_q + 1'b1;
                S_CHUNK_END: begin
                    done_q  <= next_done;
                    chunk_q <= next_chunk;
                end
                S_CAP_ERR: begin
                    err_q <= reg_rdata[7:0];
                    res_q <= RES_DEV;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        reg_addr  = A_DATA;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = '0;
        buf_rd    = 1'b0;
        buf_wr    = 1'b0;
        buf_wdata = '0;
        cmd_done  = 1'b0;
        buf_addr  = (done_q >> 1) + wcnt_q;
        unique case (state_q)
            S_RD_STAT: begin reg_rd = 1'b1; reg_addr = A_STAT; end
            S_RD_RSN:  begin reg_rd = 1'b1; reg_addr = A_RSN;  end
            S_RD_BCL:  begin reg_rd = 1'b1; reg_addr = A_BCL;  end
            S_RD_BCH:  begin reg_rd = 1'b1; reg_addr = A_BCH;  end
            S_PKT: begin
                reg_wr    = 1'b1;
                reg_wdata = pkt_q[pidx*DW +: DW];
            end
            S_XIN_REQ: reg_rd = 1'b1;
            S_XIN_CAP: begin
                buf_wr    = real_word;
                buf_wdata = reg_rdata;
            end
            S_XOUT: begin
                reg_wr    = 1'b1;
                buf_rd    = real_word;
                reg_wdata = real_word ? buf_rdata : '0;
            end
            S_RD_ERR:  begin reg_rd = 1'b1; reg_addr = A_ERR; end
            S_FINISH:  cmd_done = 1'b1;
            default: ;
        endcase
    end

    assign busy       = (state_q != S_IDLE);
    assign res_code   = res_q;
    assign res_err    = err_q;
    assign done_bytes = done_q;

endmodule

// File: rtl/pkt_phase_seq_chk.sv
module pkt_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       cmd_done,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       buf_rd,
    input logic       buf_wr
);
    // R2: nothing touches the device while idle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_rd && !reg_wr));

    // R3: one register access direction per cycle
    a_r3_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> !reg_wr);

    // R5: a buffer store follows a data register read
    a_r5_store_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> $past(reg_rd && reg_addr == 3'd0));

    // R6: a buffer fetch goes out on the data register in the same cycle
    a_r6_fetch_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> (reg_wr && reg_addr == 3'd0));

    // R12: completion is a single pulse and leaves the block idle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (!cmd_done && !busy));
endmodule

bind pkt_phase_seq pkt_phase_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cmd_done (cmd_done),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .buf_rd   (buf_rd),
    .buf_wr   (buf_wr)
);

// File: tb/tb_pkt_phase_seq.sv
`timescale 1ns/1ps
module tb_pkt_phase_seq;
    localparam int BC_W   = 16;
    localparam int DW     = 16;
    localparam int SETTLE = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      req_dir = '0;
    logic [BC_W-1:0] req_total = '0, req_chunk = '0;
    logic            req_pkt12 = 1'b0;
    logic [127:0]    pkt_data = '0;
    logic            irq = 1'b0;
    logic [2:0]      reg_addr;
    logic            reg_rd, reg_wr;
    logic [DW-1:0]   reg_wdata, reg_rdata, buf_rdata, buf_wdata;
    logic [BC_W-1:0] buf_addr, done_bytes;
    logic            buf_rd, buf_wr, busy, cmd_done;
    logic [1:0]      res_code;
    logic [7:0]      res_err;

    always #2.5 clk = ~clk;

    pkt_phase_seq #(.SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_dir(req_dir),
        .req_total(req_total), .req_chunk(req_chunk), .req_pkt12(req_pkt12),
        .pkt_data(pkt_data), .irq(irq), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .busy(busy),
        .cmd_done(cmd_done), .res_code(res_code), .res_err(res_err),
        .done_bytes(done_bytes)
    );

    // Device and buffer models
    logic [7:0]  dev_regs [0:7];
    logic [15:0] dev_seq;
    assign buf_rdata = 16'hB000 ^ buf_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            dev_seq   <= '0;
        end else if (reg_rd) begin
            if (reg_addr == 3'd0) begin
                reg_rdata <= 16'hC000 + dev_seq;
                dev_seq   <= dev_seq + 1'b1;
            end else begin
                reg_rdata <= {8'h00, dev_regs[reg_addr]};
            end
        end
    end

    // Scoreboard
    typedef struct packed {
        logic        kind;   // 0: data register write, 1: buffer write
        logic [15:0] addr;
        logic [15:0] data;
    } item_t;
    typedef struct {
        item_t it;
        string rq;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_err = 0, acc_cnt = 0;
    bit done_seen = 0;
    bit finished = 0;
    logic [15:0] exp_seq = '0;

    task automatic chk(input bit ok, input string rq, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic mon_item(input logic kind, input logic [15:0] addr, input logic [15:0] data);
        item_t got;
        got = '{kind: kind, addr: addr, data: data};
        if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected transfer", {7'd0, got}, 40'd0);
        end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(got == e.it, e.rq, {7'd0, got}, {7'd0, e.it});
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rd || reg_wr) acc_cnt++;
            if (cmd_done) done_seen = 1;
            if (reg_wr && reg_addr == 3'd0) mon_item(1'b0, 16'h0, reg_wdata);
            if (buf_wr) mon_item(1'b1, buf_addr, buf_wdata);
        end
    end

    // Driver tasks
    logic [BC_W-1:0] m_total, m_chunk, m_done;

    task automatic push(input logic kind, input logic [15:0] addr, input logic [15:0] data, input string rq);
        exp_t e;
        e.it = '{kind: kind, addr: addr, data: data};
        e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic start_req(input logic [1:0] dir, input logic [15:0] total,
                             input logic [15:0] chunk, input bit p12);
        @(negedge clk);
        req_dir = dir; req_total = total; req_chunk = chunk; req_pkt12 = p12;
        for (int i = 0; i < 8; i++) pkt_data[16*i +: 16] = 16'h5100 + 16'(i);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_total = total; m_chunk = chunk; m_done = '0;
    endtask

    task automatic set_dev(input logic [7:0] st, input logic [7:0] rsn,
                           input logic [15:0] cnt, input logic [7:0] err);
        dev_regs[7] = st; dev_regs[2] = rsn;
        dev_regs[4] = cnt[7:0]; dev_regs[5] = cnt[15:8];
        dev_regs[1] = err;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq = 1'b1;
        @(negedge clk); irq = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_packet(input bit p12);
        int n;
        n = p12 ? 6 : 8;
        for (int i = 0; i < n; i++) push(1'b0, 16'h0, 16'h5100 + 16'(i), "R4 packet word");
    endtask

    // Model of chunk bookkeeping from R5/R6/R7
    task automatic exp_chunk(input bit rd, input logic [15:0] len);
        logic [15:0] eff, use_w, all_w, rem;
        eff   = (len < m_chunk) ? len : m_chunk;
        use_w = eff >> 1;
        all_w = len >> 1;
        for (int k = 0; k < 32'(all_w); k++) begin
            if (rd) begin
                if (k < 32'(use_w)) push(1'b1, (m_done >> 1) + 16'(k), 16'hC000 + exp_seq, "R5 stored word");
                exp_seq = exp_seq + 1'b1;
            end else begin
                if (k < 32'(use_w)) push(1'b0, 16'h0, 16'hB000 ^ ((m_done >> 1) + 16'(k)), "R6 buffer word");
                else                push(1'b0, 16'h0, 16'h0000, "R6 zero pad");
            end
        end
        m_done  = m_done + len;
        rem     = (m_total > m_done) ? m_total - m_done : 16'd0;
        m_chunk = (rem < m_chunk) ? rem : m_chunk;
    endtask

    task automatic wait_done(input string rq);
        int t;
        t = 0;
        while (!done_seen && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done_seen, rq, 40'(done_seen), 40'd1);
        done_seen = 0;
    endtask

    task automatic check_result(input logic [1:0] code, input logic [7:0] err, input string rq);
        chk(res_code == code, rq, 40'(res_code), 40'(code));
        chk(res_err == err, rq, 40'(res_err), 40'(err));
        chk(done_bytes == m_done, "R7 done bytes", 40'(done_bytes), 40'(m_done));
        chk(exp_q.size() == 0, "R6 pending transfers", 40'(exp_q.size()), 40'd0);
        chk(!busy, "R12 busy after done", 40'(busy), 40'd0);
    endtask

    task automatic cmd_out(input bit p12);
        int gap;
        set_dev(8'h58, 8'h01, 16'd0, 8'h00);
        exp_packet(p12);
        pulse_irq();
        gap = 0;
        while (!(reg_wr && reg_addr == 3'd0) && gap < 500) begin
            @(negedge clk);
            gap++;
        end
        chk(gap >= SETTLE, "R4 settle delay", 40'(gap), 40'(SETTLE));
        idle(20);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) dev_regs[i] = 8'h00;
        idle(4);
        // R1: reset state
        chk(!busy && !cmd_done, "R1 busy/done", {38'd0, busy, cmd_done}, 40'd0);
        chk(res_code == 2'd0 && res_err == 8'd0 && done_bytes == '0, "R1 results",
            {22'd0, res_code, res_err, 8'(done_bytes)}, 40'd0);
        rst_n = 1'b1;
        idle(3);

        // R2: interrupt while idle
        set_dev(8'h58, 8'h02, 16'd8, 8'h00);
        pulse_irq();
        idle(20);
        chk(acc_cnt == 0, "R2 idle irq access", 40'(acc_cnt), 40'd0);
        chk(!busy, "R2 idle irq busy", 40'(busy), 40'd0);

        // Read request, short packet, fitting chunk then overrun chunk
        start_req(2'd1, 16'd12, 16'd8, 1'b1);
        cmd_out(1'b1);
        set_dev(8'h58, 8'h02, 16'd8, 8'h00);
        exp_chunk(1'b1, 16'd8);
        pulse_irq(); idle(60);
        set_dev(8'h58, 8'h02, 16'd6, 8'h00);
        exp_chunk(1'b1, 16'd6);
        pulse_irq(); idle(60);
        set_dev(8'h50, 8'h03, 16'd0, 8'h00);
        pulse_irq();
        wait_done("R10 done ok");
        check_result(2'd0, 8'h00, "R10 done ok result");
        idle(10);
        chk(res_code == 2'd0 && done_bytes == 16'd14, "R12 results held",
            {22'd0, res_code, 16'(done_bytes)}, 40'd14);

        // Write request, long packet, zero padding, done with ERR
        start_req(2'd2, 16'd6, 16'd4, 1'b0);
        cmd_out(1'b0);
        set_dev(8'h58, 8'h00, 16'd4, 8'h00);
        exp_chunk(1'b0, 16'd4);
        pulse_irq(); idle(60);
        set_dev(8'h58, 8'h00, 16'd4, 8'h00);
        exp_chunk(1'b0, 16'd4);
        pulse_irq(); idle(60);
        set_dev(8'h51, 8'h03, 16'd0, 8'h24);
        pulse_irq();
        wait_done("R10 done with ERR");
        check_result(2'd1, 8'h24, "R10 error capture");

        // R8: write phase on read request
        start_req(2'd1, 16'd8, 16'd8, 1'b1);
        set_dev(8'h58, 8'h00, 16'd4, 8'h00);
        pulse_irq();
        wait_done("R8 out on read");
        check_result(2'd2, 8'h00, "R8 out on read code");

        // R8: read phase on write request
        start_req(2'd2, 16'd8, 16'd8, 1'b1);
        set_dev(8'h58, 8'h02, 16'd4, 8'h00);
        pulse_irq();
        wait_done("R8 in on write");
        check_result(2'd2, 8'h00, "R8 in on write code");

        // R11: unknown phase code 0x2
        start_req(2'd1, 16'd8, 16'd8, 1'b1);
        set_dev(8'h50, 8'h02, 16'd4, 8'h00);
        pulse_irq();
        wait_done("R11 unknown phase");
        check_result(2'd3, 8'h00, "R11 unknown phase code");

        // R9 and R3: done-with-DRQ read, count above 255, chunk overrun
        start_req(2'd1, 16'h0200, 16'h0100, 1'b1);
        set_dev(8'h58, 8'h03, 16'h0104, 8'h00);
        exp_chunk(1'b1, 16'h0104);
        pulse_irq();
        wait_done("R9 done with DRQ");
        check_result(2'd0, 8'h00, "R9 done with DRQ read");
        chk(done_bytes == 16'h0104, "R3 high count byte", 40'(done_bytes), 40'h104);

        // R9: done-with-DRQ, no direction
        start_req(2'd0, 16'd8, 16'd8, 1'b1);
        set_dev(8'h58, 8'h03, 16'd4, 8'h04);
        pulse_irq();
        wait_done("R9 no direction");
        check_result(2'd1, 8'h04, "R9 no direction error");

        // R10: abort with device fault
        start_req(2'd1, 16'd8, 16'd8, 1'b1);
        set_dev(8'h60, 8'h01, 16'd0, 8'h10);
        pulse_irq();
        wait_done("R10 abort fault");
        check_result(2'd1, 8'h10, "R10 abort fault capture");

        // R10: abort without fault
        start_req(2'd1, 16'd8, 16'd8, 1'b1);
        set_dev(8'h40, 8'h01, 16'd0, 8'h77);
        pulse_irq();
        wait_done("R10 abort clean");
        check_result(2'd0, 8'h00, "R10 abort clean code");

        idle(5);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule